// File: doc/BRIEF.md
# Per-Crate Acknowledge Delay Stretcher

This block holds back the acknowledge returned to the host bus so that the long cable runs to remote crates have time to settle before the host ends its cycle. A 4-bit delay code is kept for each of the 15 crate addresses. Software selects a crate by writing the geographic address register and then writes the status word. The field at bits 11:8 of that word is stored in the table entry of the selected crate. When the link reports that a transfer is complete, the code of the selected crate sets how many extra clock cycles pass before a one-cycle host acknowledge pulse is raised.

The all-ones geographic address selects every crate at once. A status write issued while this address is selected updates all 15 entries. A transfer or a read issued under this address uses the largest code in the table, which is the most conservative choice. The code is captured at the moment the link completes, so a change of address during the wait does not alter it.

Top module: `ack_stretcher`

## Requirements
- R1: After reset every table entry is 0 and the selected geographic address is 0, so a status read returns 0 and a completed link is acknowledged without any extra wait.
- R2: A status write stores bits 11:8 of the written word into the table entry of the currently selected address (0 to 14). A status read returns that entry in bits 11:8.
- R3: Status read bits other than 11:8 are always 0.
- R4: A code C adds exactly 4*C clock cycles. If `link_done` is sampled high at clock edge t and no wait is running, `host_ack` is high for the single cycle that follows edge t+4*C.
- R5: Each of the 15 addresses keeps its own code. A write under one address leaves the entries of the other addresses unchanged.
- R6: While address 15 (all ones) is selected, a status write stores the field into all 15 entries.
- R7: While address 15 is selected, status reads and acknowledge waits use the largest code held among the 15 entries.
- R8: The code is captured when `link_done` is sampled. Later writes to the geographic address during the wait do not change the wait length.
- R9: A `link_done` pulse sampled while a wait is running is ignored. It produces no second acknowledge.
- R10: When `geo_wr` and `stat_wr` are high in the same cycle, the status write goes to the address selected before that edge. The new address applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geo_wr | input | 1 | Load the geographic address register |
| geo_wdata | input | 4 | New geographic address (15 = all crates) |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 16 | Status write data, delay code in bits 11:8 |
| stat_rdata | output | 16 | Status read data, delay code of selected address in bits 11:8 |
| link_done | input | 1 | One-cycle pulse: the link has completed its transfer |
| host_ack | output | 1 | One-cycle acknowledge to the host bus |
| wait_busy | output | 1 | High while an acknowledge is being held back |

## Verification
The acknowledge latency is measured for the five typical cable codes (0, 9, 3, 7, 15), for random codes at random addresses, and for the broadcast address. These runs separate a per-crate lookup from a shared code, and a maximum taken over the table from a simple lookup of a single entry. Directed sequences write one crate and read the others back, which shows that an entry write does not reach its neighbours. They also write under the broadcast address, which shows that a broadcast write fills every entry. Further sequences change the address or pulse `link_done` again during a wait, and issue address and status writes in the same cycle. These show whether the code is captured at the start of the wait, whether a second pulse during a wait is ignored, and how a same-cycle address and status write is ordered.

// File: rtl/ack_stretcher_pkg.sv
package ack_stretcher_pkg;

  localparam int unsigned GEO_W_DEF   = 4;
  localparam int unsigned CODE_W_DEF  = 4;
  localparam int unsigned STEP_DEF    = 4;

  // number of wait cycles for a code
  function automatic int unsigned wait_of(input int unsigned code, input int unsigned step);
    return code * step;
  endfunction

  // counter width able to hold the largest wait
  function automatic int unsigned cnt_width(input int unsigned code_w, input int unsigned step);
    return $clog2(((1 << code_w) - 1) * step + 1);
  endfunction

endpackage

// File: rtl/ack_stretcher_table.sv
module ack_stretcher_table #(
  parameter int unsigned NUM_DEST = 15,
  parameter int unsigned GEO_W    = 4,
  parameter int unsigned CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GEO_W-1:0]  sel_geo,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] sel_code,
  output logic [CODE_W-1:0] max_code
);

  localparam logic [GEO_W-1:0] BCAST = {GEO_W{1'b1}};

  logic              is_bcast;
  logic [CODE_W-1:0] entry [NUM_DEST];
  logic [CODE_W-1:0] pick;

  assign is_bcast = (sel_geo == BCAST);

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_entry
    logic hit;
    assign hit = is_bcast || (sel_geo == GEO_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= '0;
      else if (wr_en && hit)
        entry[g] <= wr_code;
    end
  end

  always_comb begin
    max_code = '0;
    for (int i = 0; i < NUM_DEST; i++)
      if (entry[i] > max_code) max_code = entry[i];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_DEST; i++)
      if (sel_geo == GEO_W'(i)) pick = entry[i];
  end

  assign sel_code = is_bcast ? max_code : pick;

endmodule

// File: rtl/ack_stretcher_counter.sv
module ack_stretcher_counter
  import ack_stretcher_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP   = 4,
  parameter int unsigned CNT_W  = cnt_width(CODE_W, STEP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              ack,
  output logic [CNT_W-1:0]  remain
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             accept;

  assign load_val = CNT_W'(wait_of(int'(code), STEP));
  assign busy     = (cnt_q != '0);
  assign accept   = start && !busy;
  assign remain   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (accept) begin
        cnt_q <= load_val;
        if (load_val == '0) ack <= 1'b1;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) ack <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ack_stretcher.sv
module ack_stretcher
  import ack_stretcher_pkg::*;
#(
  parameter int unsigned NUM_DEST  = 15,
  parameter int unsigned GEO_W     = GEO_W_DEF,
  parameter int unsigned CODE_W    = CODE_W_DEF,
  parameter int unsigned STEP      = STEP_DEF,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FIELD_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              geo_wr,
  input  logic [GEO_W-1:0]  geo_wdata,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] stat_wdata,
  output logic [DATA_W-1:0] stat_rdata,
  input  logic              link_done,
  output logic              host_ack,
  output logic              wait_busy
);

  localparam int unsigned CNT_W = cnt_width(CODE_W, STEP);

  logic [GEO_W-1:0]  geo_q;
  logic [CODE_W-1:0] wr_field;
  logic [CODE_W-1:0] sel_code;
  logic [CODE_W-1:0] max_code;
  logic [CNT_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (!rst_n)
      geo_q <= '0;
    else if (geo_wr)
      geo_q <= geo_wdata;
  end

  assign wr_field = stat_wdata[FIELD_LSB +: CODE_W];

  ack_stretcher_table #(
    .NUM_DEST(NUM_DEST), .GEO_W(GEO_W), .CODE_W(CODE_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .sel_geo(geo_q),
    .wr_code(wr_field), .sel_code(sel_code), .max_code(max_code)
  );

  ack_stretcher_counter #(
    .CODE_W(CODE_W), .STEP(STEP), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(link_done), .code(sel_code),
    .busy(wait_busy), .ack(host_ack), .remain(remain)
  );

  always_comb begin
    stat_rdata = '0;
    stat_rdata[FIELD_LSB +: CODE_W] = sel_code;
  end

endmodule

// File: rtl/ack_stretcher_checker.sv
module ack_stretcher_checker #(
  parameter int unsigned GEO_W     = 4,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned STEP      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              geo_wr,
  input logic [GEO_W-1:0]  geo_q,
  input logic              stat_wr,
  input logic [DATA_W-1:0] stat_wdata,
  input logic [DATA_W-1:0] stat_rdata,
  input logic              link_done,
  input logic              host_ack,
  input logic              wait_busy,
  input logic [CNT_W-1:0]  remain,
  input logic [CODE_W-1:0] sel_code,
  input logic [CODE_W-1:0] max_code
);

  localparam logic [GEO_W-1:0] BCAST = {GEO_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(((1 << CODE_W) - 1) * STEP);

  assert_unit_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !geo_wr && geo_q != BCAST)
      |=> stat_rdata[FIELD_LSB +: CODE_W] == $past(stat_wdata[FIELD_LSB +: CODE_W]));

  assert_other_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata & ~(DATA_W'(((1 << CODE_W) - 1)) << FIELD_LSB)) == '0);

  assert_zero_code_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_done && !wait_busy && sel_code == '0) |=> host_ack);

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_busy && remain > CNT_W'(1)) |=> (remain == $past(remain) - 1'b1) && !host_ack);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_MAX);

  assert_bcast_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (geo_q == BCAST) |-> (sel_code == max_code));

  assert_ack_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> ($past(link_done) || $past(wait_busy)));

endmodule

bind ack_stretcher ack_stretcher_checker #(
  .GEO_W(GEO_W), .CODE_W(CODE_W), .DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB),
  .CNT_W(CNT_W), .STEP(STEP)
) u_checker (
  .clk(clk), .rst_n(rst_n), .geo_wr(geo_wr), .geo_q(geo_q), .stat_wr(stat_wr),
  .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .link_done(link_done),
  .host_ack(host_ack), .wait_busy(wait_busy), .remain(remain),
  .sel_code(sel_code), .max_code(max_code)
);

// File: tb/ack_stretcher_bench.sv
module ack_stretcher_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        geo_wr = 1'b0;
  logic [3:0]  geo_wdata = '0;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic [15:0] stat_rdata;
  logic        link_done = 1'b0;
  logic        host_ack;
  logic        wait_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] model [15];
  logic [3:0] cur_geo;

  always #5 clk = ~clk;

  ack_stretcher u_ack_stretcher (
    .clk(clk), .rst_n(rst_n), .geo_wr(geo_wr), .geo_wdata(geo_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .link_done(link_done), .host_ack(host_ack), .wait_busy(wait_busy)
  );

  function automatic int exp_wait(input logic [3:0] code);
    int w;
    w = 0;
    for (int k = 0; k < int'(code); k++) w += 4;
    return w;
  endfunction

  function automatic logic [3:0] exp_code(input logic [3:0] geo);
    logic [3:0] best;
    if (geo != 4'hF) return model[geo];
    best = 0;
    foreach (model[i]) best = (model[i] > best) ? model[i] : best;
    return best;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic set_geo(input logic [3:0] g);
    @(negedge clk);
    geo_wr = 1; geo_wdata = g;
    @(negedge clk);
    geo_wr = 0;
    cur_geo = g;
  endtask

  task automatic write_code(input logic [3:0] c);
    @(negedge clk);
    stat_wr = 1;
    stat_wdata = {$urandom_range(0, 15) & 4'hF, c, 8'($urandom_range(0, 255))};
    @(negedge clk);
    stat_wr = 0;
    if (cur_geo == 4'hF) foreach (model[i]) model[i] = c;
    else model[cur_geo] = c;
  endtask

  task automatic read_check(input string req);
    @(negedge clk);
    check(req, int'(stat_rdata), int'({4'b0, exp_code(cur_geo), 8'b0}));
  endtask

  // latency in cycles after the edge that samples link_done
  task automatic link_run(input string req, input logic [3:0] new_geo, input bit change_geo,
                          input bit extra_pulse);
    int lat;
    int expw;
    int extra_acks;
    expw = exp_wait(exp_code(cur_geo));
    @(negedge clk);
    link_done = 1;
    @(negedge clk);
    link_done = 0;
    lat = 0;
    while (!host_ack && lat < 100) begin
      if (lat == 1 && change_geo) begin geo_wr = 1; geo_wdata = new_geo; end
      else geo_wr = 0;
      if (lat == 2 && extra_pulse) link_done = 1; else link_done = 0;
      @(negedge clk);
      lat++;
    end
    geo_wr = 0; link_done = 0;
    if (change_geo) cur_geo = new_geo;
    check(req, lat, expw);
    extra_acks = 0;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      if (host_ack) extra_acks++;
      if (!extra_pulse && k >= 1) break;
    end
    check({req, " single pulse"}, extra_acks, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] typ [5];
    void'($urandom(32'h5eed));
    foreach (model[i]) model[i] = 0;
    cur_geo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    read_check("R1 reset read");
    check("R1 idle ack", int'(host_ack), 0);
    link_run("R1 zero wait after reset", 0, 0, 0);

    // R4 typical cable codes on crate 2
    typ = '{4'h0, 4'h9, 4'h3, 4'h7, 4'hF};
    set_geo(2);
    foreach (typ[i]) begin
      write_code(typ[i]);
      read_check("R2 readback");
      link_run("R4 typical code latency", 0, 0, 0);
    end

    // R5 isolation
    set_geo(5); write_code(4'h6);
    set_geo(6); write_code(4'h1);
    set_geo(5); read_check("R5 crate 5 kept");
    set_geo(2); read_check("R5 crate 2 kept");
    set_geo(6); read_check("R5 crate 6 kept");

    // R7 broadcast uses maximum
    set_geo(4'hF); read_check("R7 bcast read max");
    link_run("R7 bcast latency", 0, 0, 0);

    // R6 broadcast write fills all
    write_code(4'h2);
    for (int g = 0; g < 15; g += 7) begin
      set_geo(4'(g)); read_check("R6 bcast write entry");
    end
    set_geo(14); read_check("R6 bcast write last entry");

    // R8 address change mid wait
    set_geo(3); write_code(4'hC);
    set_geo(4); write_code(4'h1);
    set_geo(3);
    link_run("R8 geo change ignored", 4'h4, 1, 0);

    // R9 second link_done during wait
    set_geo(7); write_code(4'h5);
    link_run("R9 extra pulse ignored", 0, 0, 1);

    // R10 same-cycle geo and status write
    set_geo(8); write_code(4'h0);
    set_geo(9); write_code(4'h0);
    @(negedge clk);
    geo_wr = 1; geo_wdata = 8; stat_wr = 1; stat_wdata = 16'h0B00;
    @(negedge clk);
    geo_wr = 0; stat_wr = 0;
    model[9] = 4'hB; cur_geo = 8;
    read_check("R10 new geo not written");
    set_geo(9); read_check("R10 old geo written");

    // R3 and R2 R4 random mix
    for (int n = 0; n < 40; n++) begin
      logic [3:0] g;
      g = 4'($urandom_range(0, 15));
      set_geo(g);
      if ($urandom_range(0, 3) != 0) write_code(4'($urandom_range(0, 15)));
      read_check("R3 R2 random read");
      link_run("R4 random latency", 0, 0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule